// File: doc/BRIEF.md
# Processor Power State Sequencer

This block walks a processor core through its idle and low-power states. A stop-clock request or a halt indication moves the core out of normal running. With the extended-mode enable set, the block lowers the operating point on the way in: it drops the clock ratio first, waits for that step to settle, and then drops the voltage ID. A break event reverses the sequence. The voltage ID comes back up first and the ratio follows. When extended mode is clear, the core goes straight to the plain halt or stop-grant state and keeps its full operating point.

While the core is halted or in stop-grant, a bus snoop moves the block into a snoop sub-state. In that sub-state it raises the snoop acknowledge and holds the current operating point. When the snoop has been serviced, the block returns to the idle state it came from. From either stop-grant state a sleep request gates all internal clocks, after a settling step. Dropping the request brings the block back to the stop-grant state it left, again through a settling step. A sticky error flag records sleep requests made from the wrong state. It also records snoops that arrive while the clocks are being stopped or restarted.

Each settling step lasts a parameterised number of cycles. A parameter can instead make each step wait for an external settled handshake.

Top module: `pwrseq_top`

## Requirements
- R1: A synchronous active-high reset puts the block in RUN (state code 0), with ratio_low=0, vid_low=0, snp_ack=0, clk_run=1 and proto_err=0.
- R2: In RUN, stop_req takes precedence over halt_req. When ext_en=0, stop_req leads directly to STOPG (code 2).
- R3: In RUN, stop_req with ext_en=1 starts an extended entry. The block goes to ENT_RATIO (code 3, ratio_low=1, vid_low=0), then to ENT_VID (code 4, both low), and then to XSTOPG (code 6). Each step lasts STEP_CYCLES cycles in counter mode.
- R4: A brk_evt in XSTOPG or XHALT starts the exit. The block goes to EXIT_VID (code 7, ratio_low=1, vid_low=0), then to EXIT_RATIO (code 8, both 0), and then to RUN. Each step lasts STEP_CYCLES cycles.
- R5: A snp_req in HALT (1), STOPG (2), XHALT (5) or XSTOPG (6) moves the block to SNP_HALT (9), SNP_STOPG (10), SNP_XHALT (11) or SNP_XSTOPG (12) respectively, with snp_ack=1. The block stays there until snp_done and then returns to the state it came from. A snoop takes precedence over a break event in the same cycle.
- R6: In SNP_XHALT and SNP_XSTOPG, ratio_low and vid_low both stay at 1.
- R7: A sleep_req in STOPG or XSTOPG leads to SLP_ENTER (14) for STEP_CYCLES cycles and then to SLEEP (13). In SLEEP, clk_run=0. The operating point of the originating state is kept throughout.
- R8: In SLP_ENTER, SLEEP and SLP_EXIT, snp_ack stays 0. A snoop in SLEEP does not change state.
- R9: When sleep_req falls in SLEEP, the block goes to SLP_EXIT (15) for STEP_CYCLES cycles and then back to whichever stop-grant state it left.
- R10: A sleep_req in any state other than 2, 6, 13, 14 or 15 is ignored and sets proto_err. proto_err stays set until reset.
- R11: A snp_req in SLP_ENTER or SLP_EXIT sets proto_err and does not change state.
- R12: In RUN, halt_req with no stop_req leads to HALT (1) when ext_en=0. When ext_en=1 it goes through the extended entry to XHALT (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop-clock request |
| halt_req | input | 1 | Halt indication |
| ext_en | input | 1 | Extended low-power mode enable |
| brk_evt | input | 1 | Break event, leaves halt or stop-grant |
| snp_req | input | 1 | Bus snoop request |
| snp_done | input | 1 | Snoop serviced |
| step_done | input | 1 | Settled handshake (handshake mode only) |
| sleep_req | input | 1 | Sleep request |
| ratio_low | output | 1 | Clock-ratio select, 1 = low ratio |
| vid_low | output | 1 | Voltage-ID select, 1 = low voltage |
| snp_ack | output | 1 | Snoop acknowledge |
| clk_run | output | 1 | Internal clock enable, 0 in SLEEP |
| proto_err | output | 1 | Sticky protocol-error flag |
| state_code | output | 4 | Current state code |

## Verification
The assertions check four things on every cycle. The voltage ID only falls while the ratio is already low, and the ratio only rises while the voltage is already original. The operating point stays unchanged during a snoop acknowledge, and clocks stop only out of the sleep-entry state. The assertions also check that the error flag is sticky and that no acknowledge is ever given while the clocks are stopped. Only the bench scenarios can show the rest. These are the exact step durations, the return to the correct originating state after a snoop or after sleep, the choice between the plain and extended paths, the precedence rules, and the error cases.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   localparam int unsigned STATE_W = 4;

   typedef enum logic [STATE_W-1:0] {
      S_RUN        = 4'd0,
      S_HALT       = 4'd1,
      S_STOPG      = 4'd2,
      S_ENT_RATIO  = 4'd3,
      S_ENT_VID    = 4'd4,
      S_XHALT      = 4'd5,
      S_XSTOPG     = 4'd6,
      S_EXIT_VID   = 4'd7,
      S_EXIT_RATIO = 4'd8,
      S_SNP_HALT   = 4'd9,
      S_SNP_STOPG  = 4'd10,
      S_SNP_XHALT  = 4'd11,
      S_SNP_XSTOPG = 4'd12,
      S_SLEEP      = 4'd13,
      S_SLP_ENTER  = 4'd14,
      S_SLP_EXIT   = 4'd15
   } pwr_state_e;

   function automatic logic is_step_state(pwr_state_e s);
      return (s == S_ENT_RATIO) || (s == S_ENT_VID) || (s == S_EXIT_VID) ||
             (s == S_EXIT_RATIO) || (s == S_SLP_ENTER) || (s == S_SLP_EXIT);
   endfunction

   function automatic logic is_sleep_family(pwr_state_e s);
      return (s == S_SLEEP) || (s == S_SLP_ENTER) || (s == S_SLP_EXIT);
   endfunction
endpackage

// File: rtl/pwrseq_step_timer.sv
module pwrseq_step_timer #(
   parameter int unsigned STEP_MODE   = 0,
   parameter int unsigned STEP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic hs_done,
   output logic done
);
   localparam int unsigned CW = $clog2(STEP_CYCLES + 1);

   generate
      if (STEP_MODE == 0) begin : g_counter
         logic [CW-1:0] cnt_q;
         logic          unused_hs;
         assign unused_hs = hs_done;

         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (start)
               cnt_q <= CW'(STEP_CYCLES - 1);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign done = (cnt_q == '0);
      end else begin : g_handshake
         logic armed_q;
         always_ff @(posedge clk) begin
            if (rst)
               armed_q <= 1'b0;
            else if (start)
               armed_q <= 1'b1;
            else if (hs_done)
               armed_q <= 1'b0;
         end
         assign done = armed_q & hs_done;
      end
   endgenerate
endmodule

// File: rtl/pwrseq_err_track.sv
module pwrseq_err_track
   import pwrseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  pwr_state_e state,
   input  logic       sleep_req,
   input  logic       snp_req,
   output logic       err
);
   logic bad_sleep, bad_snoop;

   assign bad_sleep = sleep_req && !is_sleep_family(state) &&
                      (state != S_STOPG) && (state != S_XSTOPG);
   assign bad_snoop = snp_req && ((state == S_SLP_ENTER) || (state == S_SLP_EXIT));

   always_ff @(posedge clk) begin
      if (rst)
         err <= 1'b0;
      else if (bad_sleep || bad_snoop)
         err <= 1'b1;
   end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
   import pwrseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       stop_req,
   input  logic       halt_req,
   input  logic       ext_en,
   input  logic       brk_evt,
   input  logic       snp_req,
   input  logic       snp_done,
   input  logic       sleep_req,
   input  logic       step_ok,
   output logic       step_start,
   output pwr_state_e state,
   output logic       ratio_low,
   output logic       vid_low,
   output logic       snp_ack,
   output logic       clk_run
);
   pwr_state_e state_q, state_d;
   logic       tgt_stop_q, tgt_stop_d;
   logic       slp_ext_q, slp_ext_d;

   always_comb begin
      state_d    = state_q;
      tgt_stop_d = tgt_stop_q;
      slp_ext_d  = slp_ext_q;
      unique case (state_q)
         S_RUN: begin
            if (stop_req) begin
               state_d    = ext_en ? S_ENT_RATIO : S_STOPG;
               tgt_stop_d = 1'b1;
            end else if (halt_req) begin
               state_d    = ext_en ? S_ENT_RATIO : S_HALT;
               tgt_stop_d = 1'b0;
            end
         end
         S_ENT_RATIO:  if (step_ok) state_d = S_ENT_VID;
         S_ENT_VID:    if (step_ok) state_d = tgt_stop_q ? S_XSTOPG : S_XHALT;
         S_HALT: begin
            if (snp_req)      state_d = S_SNP_HALT;
            else if (brk_evt) state_d = S_RUN;
         end
         S_STOPG: begin
            if (snp_req) state_d = S_SNP_STOPG;
            else if (sleep_req) begin
               state_d   = S_SLP_ENTER;
               slp_ext_d = 1'b0;
            end else if (brk_evt) state_d = S_RUN;
         end
         S_XHALT: begin
            if (snp_req)      state_d = S_SNP_XHALT;
            else if (brk_evt) state_d = S_EXIT_VID;
         end
         S_XSTOPG: begin
            if (snp_req) state_d = S_SNP_XSTOPG;
            else if (sleep_req) begin
               state_d   = S_SLP_ENTER;
               slp_ext_d = 1'b1;
            end else if (brk_evt) state_d = S_EXIT_VID;
         end
         S_EXIT_VID:   if (step_ok) state_d = S_EXIT_RATIO;
         S_EXIT_RATIO: if (step_ok) state_d = S_RUN;
         S_SNP_HALT:   if (snp_done) state_d = S_HALT;
         S_SNP_STOPG:  if (snp_done) state_d = S_STOPG;
         S_SNP_XHALT:  if (snp_done) state_d = S_XHALT;
         S_SNP_XSTOPG: if (snp_done) state_d = S_XSTOPG;
         S_SLP_ENTER:  if (step_ok) state_d = S_SLEEP;
         S_SLEEP:      if (!sleep_req) state_d = S_SLP_EXIT;
         S_SLP_EXIT:   if (step_ok) state_d = slp_ext_q ? S_XSTOPG : S_STOPG;
         default:      state_d = S_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= S_RUN;
         tgt_stop_q <= 1'b0;
         slp_ext_q  <= 1'b0;
      end else begin
         state_q    <= state_d;
         tgt_stop_q <= tgt_stop_d;
         slp_ext_q  <= slp_ext_d;
      end
   end

   assign step_start = (state_d != state_q) && is_step_state(state_d);
   assign state      = state_q;

   always_comb begin
      ratio_low = 1'b0;
      vid_low   = 1'b0;
      snp_ack   = 1'b0;
      clk_run   = (state_q != S_SLEEP);
      unique case (state_q)
         S_ENT_RATIO, S_EXIT_VID: ratio_low = 1'b1;
         S_ENT_VID, S_XHALT, S_XSTOPG: begin
            ratio_low = 1'b1;
            vid_low   = 1'b1;
         end
         S_SNP_HALT, S_SNP_STOPG: snp_ack = 1'b1;
         S_SNP_XHALT, S_SNP_XSTOPG: begin
            ratio_low = 1'b1;
            vid_low   = 1'b1;
            snp_ack   = 1'b1;
         end
         S_SLEEP, S_SLP_ENTER, S_SLP_EXIT: begin
            ratio_low = slp_ext_q;
            vid_low   = slp_ext_q;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
   import pwrseq_pkg::*;
#(
   parameter int unsigned STEP_MODE   = 0,
   parameter int unsigned STEP_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stop_req,
   input  logic               halt_req,
   input  logic               ext_en,
   input  logic               brk_evt,
   input  logic               snp_req,
   input  logic               snp_done,
   input  logic               step_done,
   input  logic               sleep_req,
   output logic               ratio_low,
   output logic               vid_low,
   output logic               snp_ack,
   output logic               clk_run,
   output logic               proto_err,
   output logic [STATE_W-1:0] state_code
);
   generate
      if (STEP_MODE > 1) begin : g_bad_mode
         $error("pwrseq_top: STEP_MODE must be 0 (counter) or 1 (handshake)");
      end
      if (STEP_CYCLES < 1) begin : g_bad_cycles
         $error("pwrseq_top: STEP_CYCLES must be at least 1");
      end
   endgenerate

   pwr_state_e cur_state;
   logic       step_start, step_ok;

   pwrseq_step_timer #(
      .STEP_MODE  (STEP_MODE),
      .STEP_CYCLES(STEP_CYCLES)
   ) timer_i (
      .clk    (clk),
      .rst    (rst),
      .start  (step_start),
      .hs_done(step_done),
      .done   (step_ok)
   );

   pwrseq_fsm fsm_i (
      .clk       (clk),
      .rst       (rst),
      .stop_req  (stop_req),
      .halt_req  (halt_req),
      .ext_en    (ext_en),
      .brk_evt   (brk_evt),
      .snp_req   (snp_req),
      .snp_done  (snp_done),
      .sleep_req (sleep_req),
      .step_ok   (step_ok),
      .step_start(step_start),
      .state     (cur_state),
      .ratio_low (ratio_low),
      .vid_low   (vid_low),
      .snp_ack   (snp_ack),
      .clk_run   (clk_run)
   );

   pwrseq_err_track err_i (
      .clk      (clk),
      .rst      (rst),
      .state    (cur_state),
      .sleep_req(sleep_req),
      .snp_req  (snp_req),
      .err      (proto_err)
   );

   assign state_code = cur_state;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
   input logic       clk,
   input logic       rst,
   input logic       ratio_low,
   input logic       vid_low,
   input logic       snp_ack,
   input logic       clk_run,
   input logic       proto_err,
   input logic [3:0] state_code
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (state_code == 4'd0) && !ratio_low && !vid_low && !proto_err);

   // R3
   vid_after_ratio_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(vid_low) |-> ratio_low && $past(ratio_low));

   // R4
   ratio_after_vid_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ratio_low) |-> !vid_low && $past(!vid_low));

   // R6
   snoop_point_hold_chk: assert property (@(posedge clk) disable iff (rst)
      snp_ack |-> $stable(ratio_low) && $stable(vid_low));

   // R7
   clock_stop_path_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(clk_run) |-> $past(state_code) == 4'd14);

   // R8
   no_ack_asleep_chk: assert property (@(posedge clk) disable iff (rst)
      snp_ack |-> clk_run);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      proto_err |=> proto_err);
endmodule

bind pwrseq_top pwrseq_chk chk_i (
   .clk       (clk),
   .rst       (rst),
   .ratio_low (ratio_low),
   .vid_low   (vid_low),
   .snp_ack   (snp_ack),
   .clk_run   (clk_run),
   .proto_err (proto_err),
   .state_code(state_code)
);

// File: tb/pwrseq_tb_top.sv
module pwrseq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int STEPS      = 4;

   logic clk = 1'b0;
   logic rst, stop_req, halt_req, ext_en, brk_evt, snp_req, snp_done, step_done, sleep_req;
   logic ratio_low, vid_low, snp_ack, clk_run, proto_err;
   logic [3:0] state_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwrseq_top #(.STEP_MODE(0), .STEP_CYCLES(STEPS)) dut_i (
      .clk(clk), .rst(rst), .stop_req(stop_req), .halt_req(halt_req), .ext_en(ext_en),
      .brk_evt(brk_evt), .snp_req(snp_req), .snp_done(snp_done), .step_done(step_done),
      .sleep_req(sleep_req), .ratio_low(ratio_low), .vid_low(vid_low), .snp_ack(snp_ack),
      .clk_run(clk_run), .proto_err(proto_err), .state_code(state_code)
   );

   typedef struct {
      logic [3:0] st;
      logic rl, vl, ack, run, err;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   finished = 0;

   // monitor: compare after every rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (state_code !== e.st || ratio_low !== e.rl || vid_low !== e.vl ||
                snp_ack !== e.ack || clk_run !== e.run || proto_err !== e.err) begin
               n_fail++;
               $display("FAIL %s: actual st=%0d rl=%b vl=%b ack=%b run=%b err=%b expected st=%0d rl=%b vl=%b ack=%b run=%b err=%b",
                        e.tag, state_code, ratio_low, vid_low, snp_ack, clk_run, proto_err,
                        e.st, e.rl, e.vl, e.ack, e.run, e.err);
            end
         end
      end
   end

   // driver: push the expectation for the coming edge, then advance one cycle
   task automatic tick(input logic [3:0] st, input logic rl, vl, ack, run, err, input string tag);
      exp_t e;
      e.st = st; e.rl = rl; e.vl = vl; e.ack = ack; e.run = run; e.err = err; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic ticks(input int n, input logic [3:0] st, input logic rl, vl, ack, run, err,
                        input string tag);
      for (int i = 0; i < n; i++) tick(st, rl, vl, ack, run, err, tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(4'd0, 0, 0, 0, 1, 0, "R1 reset");
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      {stop_req, halt_req, ext_en, brk_evt, snp_req, snp_done, step_done, sleep_req} = '0;
      @(negedge clk);
      do_reset();
      tick(4'd0, 0, 0, 0, 1, 0, "R1 idle after reset");

      // extended stop-grant entry (R3)
      ext_en = 1; stop_req = 1;
      tick(4'd3, 1, 0, 0, 1, 0, "R3 ratio step first");
      stop_req = 0;
      ticks(STEPS-1, 4'd3, 1, 0, 0, 1, 0, "R3 ratio step duration");
      ticks(STEPS, 4'd4, 1, 1, 0, 1, 0, "R3 voltage step");
      tick(4'd6, 1, 1, 0, 1, 0, "R3 extended stop-grant");

      // snoop in extended stop-grant (R5, R6)
      snp_req = 1;
      tick(4'd12, 1, 1, 1, 1, 0, "R6 snoop keeps low point");
      snp_req = 0;
      tick(4'd12, 1, 1, 1, 1, 0, "R5 wait for service");
      snp_done = 1;
      tick(4'd6, 1, 1, 0, 1, 0, "R5 return after service");
      snp_done = 0;

      // sleep from extended stop-grant (R7, R8, R9)
      sleep_req = 1;
      ticks(STEPS, 4'd14, 1, 1, 0, 1, 0, "R7 sleep entry step");
      tick(4'd13, 1, 1, 0, 0, 0, "R7 clocks stopped");
      snp_req = 1;
      tick(4'd13, 1, 1, 0, 0, 0, "R8 no ack asleep");
      snp_req = 0;
      sleep_req = 0;
      ticks(STEPS, 4'd15, 1, 1, 0, 1, 0, "R9 sleep exit step");
      tick(4'd6, 1, 1, 0, 1, 0, "R9 back to extended stop-grant");

      // exit (R4)
      brk_evt = 1;
      tick(4'd7, 1, 0, 0, 1, 0, "R4 voltage restored first");
      brk_evt = 0;
      ticks(STEPS-1, 4'd7, 1, 0, 0, 1, 0, "R4 voltage step duration");
      ticks(STEPS, 4'd8, 0, 0, 0, 1, 0, "R4 ratio restored");
      tick(4'd0, 0, 0, 0, 1, 0, "R4 running again");

      // plain halt, snoop precedence over break (R12, R5)
      ext_en = 0; halt_req = 1;
      tick(4'd1, 0, 0, 0, 1, 0, "R12 plain halt");
      halt_req = 0; snp_req = 1; brk_evt = 1;
      tick(4'd9, 0, 0, 1, 1, 0, "R5 snoop beats break");
      snp_req = 0; brk_evt = 0; snp_done = 1;
      tick(4'd1, 0, 0, 0, 1, 0, "R5 back to halt");
      snp_done = 0; brk_evt = 1;
      tick(4'd0, 0, 0, 0, 1, 0, "R12 halt break");
      brk_evt = 0;

      // plain stop-grant with precedence, sleep, snoop in exit (R2, R7, R11, R9)
      stop_req = 1; halt_req = 1;
      tick(4'd2, 0, 0, 0, 1, 0, "R2 stop beats halt");
      stop_req = 0; halt_req = 0; sleep_req = 1;
      ticks(STEPS, 4'd14, 0, 0, 0, 1, 0, "R7 plain sleep entry");
      tick(4'd13, 0, 0, 0, 0, 0, "R7 plain sleep");
      sleep_req = 0;
      tick(4'd15, 0, 0, 0, 1, 0, "R9 plain sleep exit");
      snp_req = 1;
      tick(4'd15, 0, 0, 0, 1, 1, "R11 snoop during exit");
      snp_req = 0;
      ticks(STEPS-2, 4'd15, 0, 0, 0, 1, 1, "R11 no state change");
      tick(4'd2, 0, 0, 0, 1, 1, "R9 back to plain stop-grant");
      brk_evt = 1;
      tick(4'd0, 0, 0, 0, 1, 1, "R10 error sticky");
      brk_evt = 0;

      // illegal sleep in RUN (R10)
      do_reset();
      sleep_req = 1;
      tick(4'd0, 0, 0, 0, 1, 1, "R10 sleep in run ignored");
      sleep_req = 0;
      tick(4'd0, 0, 0, 0, 1, 1, "R10 flag held");

      // extended halt, snoop, illegal sleep (R12, R6, R10)
      do_reset();
      ext_en = 1; halt_req = 1;
      tick(4'd3, 1, 0, 0, 1, 0, "R12 extended halt entry");
      halt_req = 0;
      ticks(STEPS-1, 4'd3, 1, 0, 0, 1, 0, "R12 ratio step");
      ticks(STEPS, 4'd4, 1, 1, 0, 1, 0, "R12 voltage step");
      tick(4'd5, 1, 1, 0, 1, 0, "R12 extended halt");
      snp_req = 1;
      tick(4'd11, 1, 1, 1, 1, 0, "R6 extended halt snoop");
      snp_req = 0; snp_done = 1;
      tick(4'd5, 1, 1, 0, 1, 0, "R5 back to extended halt");
      snp_done = 0; sleep_req = 1;
      tick(4'd5, 1, 1, 0, 1, 1, "R10 sleep in halt ignored");
      sleep_req = 0;

      @(posedge clk);
      #2;
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule